// File: doc/BRIEF.md
# Counted-Pin Interrupt Dispatcher

This block turns interrupt line activity on a set of pins into interrupt messages. Each pin's line is tracked as a signed count of outstanding assertions, not as a single level bit. Assert requests raise the count, deassert requests lower it, and a pulse does both in turn. A message is attempted only when a pin's count rises from zero to one. The routing for each pin comes from a configuration slice that a separate register file supplies. That slice carries the mask, trigger mode, destination mode, delivery mode, vector and destination.

Level-triggered pins are interlocked through a remote-pending bit that the block owns. Once a level message has gone out, further attempts on that pin are dropped until an end-of-interrupt arrives whose vector matches the pin. The end-of-interrupt clears the bit, and if the line is still asserted the pin is delivered again. When the register file finishes a write to a pin's slice it sends a write-done notice. On that notice an edge-mode pin loses its pending bit, and an asserted level-mode pin is retried.

All four streams use valid/ready. An input is taken on a cycle where its valid and ready are both high. The three inputs are ranked: end-of-interrupt first, then write-done, then pin events, and a lower-ranked ready is low while a higher-ranked valid is high. While a message waits for `msg_ready`, no input is accepted. While an end-of-interrupt scan runs, end-of-interrupt, write-done and pin-event inputs are all held off. The consumer may hold `msg_ready` low for any length of time, and the message fields do not change until it is taken.

Top module: `pin_irq_dispatch`

## Requirements
- R1: Each pin keeps a signed count, CNT_W bits wide (default range -8 to 7). The request code on `ev_kind` sets the change: 0 is assert (+1), 1 is deassert (-1), 2 is pulse (+1 then -1), and 3 leaves the count unchanged. Each step saturates at the ends of the range.
- R2: A delivery attempt follows a pin event only when that event takes the count from 0 to 1. All other count changes produce no message.
- R3: An attempt on a pin whose mask bit is 1 produces no message and leaves its pending bit unchanged.
- R4: For a level pin, an attempt while `rpend[p]` is 1 is dropped. Otherwise the attempt sets `rpend[p]` and sends a message. Edge pins never set `rpend`.
- R5: An end-of-interrupt with vector V visits the pins in ascending order. Each pin with `rpend` set and vector field equal to V has its bit cleared, and the pin is delivered again if its count is above zero. Messages from one scan leave in ascending pin order, and no other input is accepted until the scan and its messages complete.
- R6: A write-done notice for a pin clears its pending bit if the pin is in edge mode. If the pin is level mode with a count above zero, the notice makes a delivery attempt.
- R7: The configuration slice for pin p is `cfg_flat[22p+21:22p]`, laid out as follows: [7:0] destination, [15:8] vector, [18:16] delivery mode, [19] logical destination, [20] level trigger, [21] mask. The message copies the vector, destination, destination mode and delivery mode from the slice, and `msg_level` equals the trigger bit.
- R8: While `msg_valid` is high and `msg_ready` is low, the message fields stay stable and `ev_ready` is low.
- R9: A deassert or pulse that leaves a count negative sets `cnt_err`, which stays set until reset.
- R10: After reset, `msg_valid`, `rpend` and `cnt_err` are 0, all counts are 0, and `ev_ready` is high when no other input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Pin event request valid |
| ev_ready | output | 1 | Pin event accepted when high with valid |
| ev_pin | input | PIN_W | Pin addressed by the event |
| ev_kind | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 no change |
| wr_valid | input | 1 | Write-done notice valid |
| wr_ready | output | 1 | Write-done notice accepted |
| wr_pin | input | PIN_W | Pin whose slice was written |
| eoi_valid | input | 1 | End-of-interrupt valid |
| eoi_ready | output | 1 | End-of-interrupt accepted |
| eoi_vector | input | 8 | Vector being retired |
| cfg_flat | input | NPINS*22 | Per-pin configuration slices |
| msg_valid | output | 1 | Interrupt message valid |
| msg_ready | input | 1 | Consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_logical | output | 1 | 1 = logical destination mode |
| msg_deliv | output | 3 | Delivery mode |
| msg_level | output | 1 | 1 = level-triggered source |
| rpend | output | NPINS | Remote-pending bits, one per pin |
| cnt_err | output | 1 | Sticky negative-count flag |

## Verification
The count logic is driven with repeated asserts, balanced deassert runs, pulses from zero, and a deassert from zero. These patterns separate a true 0-to-1 trigger from one that fires on any rise, and they expose wraparound where saturation is required. Level pins go through assert, re-assert while pending, end-of-interrupt with a wrong vector and then the right one, and end-of-interrupt with the line already dropped. Those cases show whether the pending interlock and re-delivery respond to the count or to the event. Write-done notices are sent with the trigger switched to edge and back to level, and two level pins that share one vector test the scan order and stability under a stalled `msg_ready`.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int CFG_W = 22;

  typedef struct packed {
    logic       mask;
    logic       level;
    logic       logical;
    logic [2:0] deliv;
    logic [7:0] vector;
    logic [7:0] dest;
  } pin_cfg_t;

  typedef enum logic [1:0] {
    EV_ASSERT   = 2'd0,
    EV_DEASSERT = 2'd1,
    EV_PULSE    = 2'd2,
    EV_NOP      = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_SEND = 2'd2
  } eng_state_e;
endpackage

// File: rtl/irq_acount_bank.sv
module irq_acount_bank
  import irq_dispatch_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int CNT_W = 4,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic [PIN_W-1:0]         upd_pin,
  input  ev_kind_e                 upd_kind,
  output logic [NPINS*CNT_W-1:0]   cnt_flat,
  output logic                     err
);
  localparam logic [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] inc_sat(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + ONE;
  endfunction

  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] v);
    return (v == CMIN) ? v : v - ONE;
  endfunction

  logic [NPINS-1:0] neg_hit;
  logic             err_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [CNT_W-1:0] c_q, c_nx;
    logic             sel;

    assign sel = upd_en && (upd_pin == PIN_W'(g));

    always_comb begin
      unique case (upd_kind)
        EV_ASSERT:   c_nx = inc_sat(c_q);
        EV_DEASSERT: c_nx = dec_sat(c_q);
        EV_PULSE:    c_nx = dec_sat(inc_sat(c_q));
        default:     c_nx = c_q;
      endcase
    end

    assign neg_hit[g] = sel && c_nx[CNT_W-1] &&
                        (upd_kind == EV_DEASSERT || upd_kind == EV_PULSE);

    always_ff @(posedge clk) begin
      if (!rst_n)   c_q <= '0;
      else if (sel) c_q <= c_nx;
    end

    assign cnt_flat[g*CNT_W +: CNT_W] = c_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (|neg_hit);
  end

  assign err = err_q;

  // R9: once raised, the error flag holds until reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/irq_msg_slot.sv
module irq_msg_slot
  import irq_dispatch_pkg::*;
#(
  parameter int NPINS = 32,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  pin_cfg_t         load_cfg,
  input  logic [PIN_W-1:0] load_pin,
  input  logic             ready,
  output logic             valid,
  output pin_cfg_t         cfg_q,
  output logic [PIN_W-1:0] pin_q
);
  logic valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cfg_q   <= '0;
      pin_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      cfg_q   <= load_cfg;
      pin_q   <= load_pin;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;

  // R8: a stalled message keeps its contents
  a_r8_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !ready |=> valid_q && $stable(cfg_q) && $stable(pin_q));

  // R8: a waiting message is never overwritten
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q);
endmodule

// File: rtl/pin_irq_dispatch.sv
module pin_irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int CNT_W = 4,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_valid,
  output logic                   ev_ready,
  input  logic [PIN_W-1:0]       ev_pin,
  input  logic [1:0]             ev_kind,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [PIN_W-1:0]       wr_pin,
  input  logic                   eoi_valid,
  output logic                   eoi_ready,
  input  logic [7:0]             eoi_vector,
  input  logic [NPINS*CFG_W-1:0] cfg_flat,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic [7:0]             msg_vector,
  output logic [7:0]             msg_dest,
  output logic                   msg_logical,
  output logic [2:0]             msg_deliv,
  output logic                   msg_level,
  output logic [NPINS-1:0]       rpend,
  output logic                   cnt_err
);
  localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NPINS - 1);

  pin_cfg_t         cfg_arr [NPINS];
  logic [CNT_W-1:0] cnt_arr [NPINS];
  logic [NPINS*CNT_W-1:0] cnt_flat;

  for (genvar g = 0; g < NPINS; g++) begin : g_unpack
    assign cfg_arr[g] = pin_cfg_t'(cfg_flat[g*CFG_W +: CFG_W]);
    assign cnt_arr[g] = cnt_flat[g*CNT_W +: CNT_W];
  end

  eng_state_e       state_q;
  logic [PIN_W-1:0] scan_idx_q;
  logic             scan_done_q;
  logic             ret_scan_q;
  logic [7:0]       eoi_vec_q;
  logic [NPINS-1:0] rpend_q;

  ev_kind_e         kind;
  logic             eoi_acc, wr_acc, ev_acc, rise;
  logic [PIN_W-1:0] cur_pin;
  pin_cfg_t         cur_cfg;
  logic             cur_pos, match, clr, try_en, rp_eff, fire, set_rp;
  pin_cfg_t         slot_cfg;
  logic [PIN_W-1:0] slot_pin;

  assign kind = ev_kind_e'(ev_kind);

  always_comb begin
    eoi_ready = (state_q == ST_IDLE);
    wr_ready  = (state_q == ST_IDLE) && !eoi_valid;
    ev_ready  = (state_q == ST_IDLE) && !eoi_valid && !wr_valid;
    eoi_acc   = eoi_valid && eoi_ready;
    wr_acc    = wr_valid && wr_ready;
    ev_acc    = ev_valid && ev_ready;
    rise      = (cnt_arr[ev_pin] == '0) && (kind == EV_ASSERT || kind == EV_PULSE);

    if (state_q == ST_SCAN) cur_pin = scan_idx_q;
    else if (wr_valid)      cur_pin = wr_pin;
    else                    cur_pin = ev_pin;

    cur_cfg = cfg_arr[cur_pin];
    cur_pos = !cnt_arr[cur_pin][CNT_W-1] && (cnt_arr[cur_pin] != '0);
    match   = (state_q == ST_SCAN) && rpend_q[cur_pin] && (cur_cfg.vector == eoi_vec_q);
    clr     = match || (wr_acc && !cur_cfg.level);
    try_en  = (match && cur_pos) || (wr_acc && cur_cfg.level && cur_pos) || (ev_acc && rise);
    rp_eff  = rpend_q[cur_pin] && !clr;
    fire    = try_en && !cur_cfg.mask && !(cur_cfg.level && rp_eff);
    set_rp  = fire && cur_cfg.level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      scan_idx_q  <= '0;
      scan_done_q <= 1'b0;
      ret_scan_q  <= 1'b0;
      eoi_vec_q   <= '0;
      rpend_q     <= '0;
    end else begin
      if (clr)    rpend_q[cur_pin] <= 1'b0;
      if (set_rp) rpend_q[cur_pin] <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (eoi_acc) begin
            state_q    <= ST_SCAN;
            scan_idx_q <= '0;
            eoi_vec_q  <= eoi_vector;
          end else if (fire) begin
            state_q    <= ST_SEND;
            ret_scan_q <= 1'b0;
          end
        end
        ST_SCAN: begin
          scan_idx_q <= scan_idx_q + 1'b1;
          if (fire) begin
            state_q     <= ST_SEND;
            ret_scan_q  <= 1'b1;
            scan_done_q <= (scan_idx_q == LAST_PIN);
          end else if (scan_idx_q == LAST_PIN) begin
            state_q <= ST_IDLE;
          end
        end
        default: begin
          if (msg_ready)
            state_q <= (ret_scan_q && !scan_done_q) ? ST_SCAN : ST_IDLE;
        end
      endcase
    end
  end

  irq_acount_bank #(.NPINS(NPINS), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (ev_acc),
    .upd_pin  (ev_pin),
    .upd_kind (kind),
    .cnt_flat (cnt_flat),
    .err      (cnt_err)
  );

  irq_msg_slot #(.NPINS(NPINS)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fire),
    .load_cfg (cur_cfg),
    .load_pin (cur_pin),
    .ready    (msg_ready),
    .valid    (msg_valid),
    .cfg_q    (slot_cfg),
    .pin_q    (slot_pin)
  );

  assign msg_vector  = slot_cfg.vector;
  assign msg_dest    = slot_cfg.dest;
  assign msg_logical = slot_cfg.logical;
  assign msg_deliv   = slot_cfg.deliv;
  assign msg_level   = slot_cfg.level;
  assign rpend       = rpend_q;

  // R4: a level message in flight always has its pin marked pending
  a_r4_level_pending: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_level |-> rpend_q[slot_pin]);

  // R5: no pin event or write notice enters during a scan
  a_r5_scan_holds_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SCAN |-> !ev_ready && !wr_ready);

  // R6: write-done on an edge pin leaves its pending bit clear
  a_r6_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && !cfg_arr[wr_pin].level |=> !rpend_q[$past(wr_pin)]);

  // R8: inputs are refused while a message waits
  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |-> !ev_ready);
endmodule

// File: tb/pin_irq_dispatch_bench.sv
module pin_irq_dispatch_bench;
  localparam int NPINS = 32;
  localparam int PIN_W = 5;
  localparam int CW    = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, wr_valid = 1'b0, eoi_valid = 1'b0, msg_ready = 1'b0;
  logic ev_ready, wr_ready, eoi_ready;
  logic [PIN_W-1:0] ev_pin = '0, wr_pin = '0;
  logic [1:0] ev_kind = '0;
  logic [7:0] eoi_vector = '0;
  logic [NPINS*CW-1:0] cfg_flat;
  logic msg_valid, msg_logical, msg_level, cnt_err;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_deliv;
  logic [NPINS-1:0] rpend;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pin_irq_dispatch #(.NPINS(NPINS), .CNT_W(4)) u_pin_irq_dispatch (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_pin(ev_pin), .ev_kind(ev_kind),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_pin(wr_pin),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_vector(eoi_vector),
    .cfg_flat(cfg_flat),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_deliv(msg_deliv),
    .msg_level(msg_level), .rpend(rpend), .cnt_err(cnt_err)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    summary();
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic set_cfg(input int p, input logic m, input logic lvl, input logic lg,
                         input logic [2:0] dl, input logic [7:0] vec, input logic [7:0] dst);
    cfg_flat[p*CW +: CW] = {m, lvl, lg, dl, vec, dst};
  endtask

  task automatic send_ev(input int p, input logic [1:0] k);
    @(negedge clk);
    ev_pin = PIN_W'(p); ev_kind = k; ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    @(posedge clk); #1 ev_valid = 1'b0;
  endtask

  task automatic send_wr(input int p);
    @(negedge clk);
    wr_pin = PIN_W'(p); wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_vector = v; eoi_valid = 1'b1;
    while (!eoi_ready) @(negedge clk);
    @(posedge clk); #1 eoi_valid = 1'b0;
  endtask

  task automatic expect_msg(input string req, input logic [7:0] vec, input logic [7:0] dst,
                            input logic lvl, input logic lg, input logic [2:0] dl, input int stall);
    int n = 0;
    @(negedge clk);
    while (!msg_valid && n < 100) begin @(negedge clk); n++; end
    chk(req, "msg_valid", 32'(msg_valid), 1);
    if (msg_valid) begin
      chk(req, "vector", 32'(msg_vector), 32'(vec));
      chk(req, "dest", 32'(msg_dest), 32'(dst));
      chk(req, "level", 32'(msg_level), 32'(lvl));
      chk(req, "logical", 32'(msg_logical), 32'(lg));
      chk(req, "deliv", 32'(msg_deliv), 32'(dl));
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk("R8", "stall valid", 32'(msg_valid), 1);
        chk("R8", "stall dest", 32'(msg_dest), 32'(dst));
        chk("R8", "stall ev_ready", 32'(ev_ready), 0);
      end
      msg_ready = 1'b1;
      @(posedge clk); #1 msg_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input string req);
    int seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        seen++;
        msg_ready = 1'b1;
        @(posedge clk); #1 msg_ready = 1'b0;
      end else if (ev_ready) break;
    end
    chk(req, "unexpected messages", 32'(seen), 0);
  endtask

  // R10
  task automatic t_reset();
    @(negedge clk);
    chk("R10", "msg_valid", 32'(msg_valid), 0);
    chk("R10", "rpend", rpend, 0);
    chk("R10", "cnt_err", 32'(cnt_err), 0);
    chk("R10", "ev_ready", 32'(ev_ready), 1);
  endtask

  // R1 R2 R7: edge pin, only 0->1 fires, pulse nets zero
  task automatic t_edge_counting();
    set_cfg(3, 0, 0, 0, 3'd0, 8'h41, 8'h12);
    send_ev(3, 2'd0); expect_msg("R2", 8'h41, 8'h12, 0, 0, 3'd0, 0);
    send_ev(3, 2'd0); expect_none("R2");
    send_ev(3, 2'd1); expect_none("R2");
    send_ev(3, 2'd1); expect_none("R2");
    send_ev(3, 2'd0); expect_msg("R2", 8'h41, 8'h12, 0, 0, 3'd0, 0);
    send_ev(3, 2'd1); expect_none("R2");
    send_ev(3, 2'd2); expect_msg("R1", 8'h41, 8'h12, 0, 0, 3'd0, 0);
    send_ev(3, 2'd3); expect_none("R1");
    send_ev(3, 2'd0); expect_msg("R1", 8'h41, 8'h12, 0, 0, 3'd0, 0);
    chk("R4", "edge rpend", 32'(rpend[3]), 0);
  endtask

  // R3
  task automatic t_masked();
    set_cfg(5, 1, 1, 0, 3'd0, 8'h45, 8'h05);
    send_ev(5, 2'd0); expect_none("R3");
    chk("R3", "rpend masked", 32'(rpend[5]), 0);
  endtask

  // R4 R5: pending interlock and vector-matched retire
  task automatic t_level_eoi();
    set_cfg(7, 0, 1, 1, 3'd1, 8'h50, 8'hA5);
    send_ev(7, 2'd0); expect_msg("R4", 8'h50, 8'hA5, 1, 1, 3'd1, 0);
    chk("R4", "rpend set", 32'(rpend[7]), 1);
    send_ev(7, 2'd1); send_ev(7, 2'd0); expect_none("R4");
    send_eoi(8'h51); expect_none("R5");
    chk("R5", "rpend kept on wrong vector", 32'(rpend[7]), 1);
    send_eoi(8'h50); expect_msg("R5", 8'h50, 8'hA5, 1, 1, 3'd1, 0);
    chk("R5", "rpend after redeliver", 32'(rpend[7]), 1);
    send_ev(7, 2'd1); send_eoi(8'h50); expect_none("R5");
    chk("R5", "rpend cleared", 32'(rpend[7]), 0);
  endtask

  // R6
  task automatic t_write_done();
    send_ev(7, 2'd0); expect_msg("R6", 8'h50, 8'hA5, 1, 1, 3'd1, 0);
    set_cfg(7, 0, 0, 1, 3'd1, 8'h50, 8'hA5);
    send_wr(7); expect_none("R6");
    chk("R6", "edge write clears rpend", 32'(rpend[7]), 0);
    set_cfg(7, 0, 1, 1, 3'd1, 8'h50, 8'hA5);
    send_wr(7); expect_msg("R6", 8'h50, 8'hA5, 1, 1, 3'd1, 0);
    chk("R6", "level write sets rpend", 32'(rpend[7]), 1);
    send_wr(7); expect_none("R6");
    send_ev(7, 2'd1);
  endtask

  // R5 R8: ordering and back-pressure
  task automatic t_order();
    set_cfg(9, 0, 1, 0, 3'd2, 8'h60, 8'h99);
    set_cfg(4, 0, 1, 0, 3'd2, 8'h60, 8'h44);
    send_ev(9, 2'd0); expect_msg("R4", 8'h60, 8'h99, 1, 0, 3'd2, 0);
    send_ev(4, 2'd0); expect_msg("R4", 8'h60, 8'h44, 1, 0, 3'd2, 0);
    send_eoi(8'h60);
    expect_msg("R5", 8'h60, 8'h44, 1, 0, 3'd2, 3);
    expect_msg("R5", 8'h60, 8'h99, 1, 0, 3'd2, 0);
    expect_none("R5");
  endtask

  // R9
  task automatic t_negative();
    set_cfg(12, 0, 0, 0, 3'd0, 8'h6C, 8'h0C);
    send_ev(12, 2'd1); expect_none("R9");
    chk("R9", "cnt_err set", 32'(cnt_err), 1);
    send_ev(12, 2'd0); expect_none("R2");
    send_ev(12, 2'd0); expect_msg("R2", 8'h6C, 8'h0C, 0, 0, 3'd0, 0);
    chk("R9", "cnt_err sticky", 32'(cnt_err), 1);
  endtask

  // R1 saturation
  task automatic t_saturate();
    set_cfg(14, 0, 0, 0, 3'd0, 8'h70, 8'h0E);
    send_ev(14, 2'd0); expect_msg("R1", 8'h70, 8'h0E, 0, 0, 3'd0, 0);
    for (int i = 0; i < 8; i++) begin send_ev(14, 2'd0); expect_none("R1"); end
    for (int i = 0; i < 7; i++) begin send_ev(14, 2'd1); expect_none("R1"); end
    send_ev(14, 2'd0); expect_msg("R1", 8'h70, 8'h0E, 0, 0, 3'd0, 0);
  endtask

  initial begin
    for (int p = 0; p < NPINS; p++) set_cfg(p, 1, 0, 0, 3'd0, 8'h00, 8'h00);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_edge_counting();
    t_masked();
    t_level_eoi();
    t_write_done();
    t_order();
    t_negative();
    t_saturate();
    summary();
  end
endmodule